// File: doc/BRIEF.md
# Two-Level Interrupt Controller

This controller gathers 32 primary request lines and 11 secondary request lines into one normal interrupt output and one fast interrupt output. The secondary lines come in four groups: three groups of three lines each for serial ports (receive, transmit, error) and one group of two lines for a converter (touch, conversion done). Each group has its own pending bits and mask bits, and the group drives a single primary line called its parent. Software sees seven word registers on a small register bus. The bus writes synchronously and reads combinationally.

A primary line records a request in its source-pending bit when the line goes from low to high. Among the pending sources that are not masked and not selected for the fast path, the lowest-numbered one is moved into a one-hot serving register. That move happens only when the serving register is empty, and the normal interrupt output stays high while it holds a source. The serving register is controlled by a two-state machine. In state IDLE no source is being served. The ARM transition goes from IDLE to SERVE: it fires when at least one candidate exists and loads the lowest candidate. In state SERVE exactly one bit is held, and the machine ignores new candidates. The RETIRE transition goes from SERVE back to IDLE: it fires when software writes a one to the held bit of the serving register. A mode register picks one source for the fast output, and that source is taken out of the normal arbitration.

Top module: `cascade_intc`

## Requirements
- R1: After reset, the following registers read 0: source-pending, serving, offset, secondary-pending and mode. The primary mask reads 0xFFFFFFFF and the secondary mask reads 0x7FF. The normal interrupt output and the fast interrupt output are both low.
- R2: A source-pending bit is set by a low-to-high transition of its request line. A line that stays high does not set the bit again after software has cleared it.
- R3: The source-pending, serving and secondary-pending registers are write-one-to-clear: writing 1 at a bit clears that bit, and writing 0 at a bit leaves it unchanged. If a new rising edge arrives in the same cycle as a clear of the same bit, the bit stays set.
- R4: A primary mask bit of 1 keeps its source away from both outputs, while the source-pending bit is still recorded. Clearing the mask bit lets the source through.
- R5: The serving register never has more than one bit set. It is loaded only from state IDLE, with the lowest-numbered pending source that is unmasked and not selected in the mode register. A request with a lower number that arrives during SERVE does not displace the source being served.
- R6: The offset register and the `serve_idx` output give the bit index (0 to 31) of the source being served.
- R7: Secondary bits 0–2, 3–5 and 6–8 are the three serial-port groups, with parents on primary lines 28, 23 and 15. Secondary bits 9 and 10 form the converter group, with its parent on primary line 31. A parent line is high when any bit of its group is pending and not masked in the secondary mask (1 = masked). The primary request inputs at the four parent positions are ignored.
- R8: Secondary-pending bits latch on rising edges of `sub_req` and are cleared only by writes to the secondary-pending register. Clearing a parent's source-pending or serving bit leaves the group's secondary bits unchanged.
- R9: Primary lines 6 and 24 are reserved, and their source-pending bits never become 1.
- R10: When a source is selected in the mode register, is pending and is unmasked, the fast output goes high and the normal output is not driven by that source. A mode value of 0 keeps the fast output low.
- R11: The register word addresses are: 0 = source-pending, 1 = primary mask, 2 = mode, 3 = serving, 4 = offset (read-only), 5 = secondary-pending, 6 = secondary mask. Address 7 reads 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| irq_req | input | 32 | Primary request lines |
| sub_req | input | 11 | Secondary request lines |
| bus_addr | input | 3 | Register word address |
| bus_we | input | 1 | Write strobe, acts at the clock edge |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, combinational from `bus_addr` |
| irq_o | output | 1 | Normal interrupt output |
| fiq_o | output | 1 | Fast interrupt output |
| serve_idx | output | 5 | Index of the source being served |

## Verification
The assertions assume that software clears a source-pending bit before it retires the matching serving bit, so that retiring a source does not simply load the same source again. They also assume that the mode register never holds more than one set bit. The stimulus follows both rules in every scenario. Each scenario uses its own request lines and lowers them again before it ends, so that every edge the bench counts on is a fresh one.

// File: rtl/intc_pkg.sv
package intc_pkg;
    localparam int unsigned SRC_LINES = 32;
    localparam int unsigned SUB_LINES = 11;
    localparam int unsigned NUM_GRP   = 4;

    localparam int unsigned GRP_LO     [NUM_GRP] = '{0, 3, 6, 9};
    localparam int unsigned GRP_CNT    [NUM_GRP] = '{3, 3, 3, 2};
    localparam int unsigned GRP_PARENT [NUM_GRP] = '{28, 23, 15, 31};

    localparam logic [SRC_LINES-1:0] RSVD_LINES = 32'h0100_0040;

    typedef enum logic [2:0] {
        RA_SRCPEND = 3'd0,
        RA_MASK    = 3'd1,
        RA_MODE    = 3'd2,
        RA_SERVE   = 3'd3,
        RA_OFFSET  = 3'd4,
        RA_SUBPEND = 3'd5,
        RA_SUBMASK = 3'd6
    } reg_addr_e;

    typedef enum logic {
        ST_IDLE  = 1'b0,
        ST_SERVE = 1'b1
    } serve_state_e;

    function automatic logic [SUB_LINES-1:0] grp_bits(int unsigned g);
        logic [SUB_LINES-1:0] m;
        m = '0;
        for (int i = 0; i < int'(SUB_LINES); i++)
            if (i >= int'(GRP_LO[g]) && i < int'(GRP_LO[g] + GRP_CNT[g]))
                m[i] = 1'b1;
        return m;
    endfunction

    function automatic logic [SRC_LINES-1:0] parent_bits();
        logic [SRC_LINES-1:0] m;
        m = '0;
        for (int g = 0; g < int'(NUM_GRP); g++)
            m[GRP_PARENT[g]] = 1'b1;
        return m;
    endfunction

    function automatic logic [$clog2(SRC_LINES)-1:0] first_set(logic [SRC_LINES-1:0] v);
        logic [$clog2(SRC_LINES)-1:0] r;
        r = '0;
        for (int i = int'(SRC_LINES) - 1; i >= 0; i--)
            if (v[i]) r = i[$clog2(SRC_LINES)-1:0];
        return r;
    endfunction
endpackage

// File: rtl/intc_pend_latch.sv
module intc_pend_latch #(
    parameter int unsigned W = 32
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic [W-1:0] line_i,
    input  logic [W-1:0] clr_i,
    output logic [W-1:0] pend_o
);
    logic [W-1:0] line_q;
    logic [W-1:0] rise;

    assign rise = line_i & ~line_q;

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            line_q <= '0;
            pend_o <= '0;
        end else begin
            line_q <= line_i;
            pend_o <= (pend_o & ~clr_i) | rise;
        end
    end

    // R2
    edge_sets_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (rise != '0) |=> ((pend_o & $past(rise)) == $past(rise)));

    // R3
    w1c_clears_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (clr_i != '0) |=> ((pend_o & $past(clr_i & ~rise)) == '0));
endmodule

// File: rtl/intc_sub_fold.sv
module intc_sub_fold
    import intc_pkg::*;
#(
    parameter int unsigned SRC_W = SRC_LINES,
    parameter int unsigned SUB_W = SUB_LINES
) (
    input  logic [SUB_W-1:0] sub_pend_i,
    input  logic [SUB_W-1:0] sub_mask_i,
    input  logic [SRC_W-1:0] req_i,
    output logic [SRC_W-1:0] line_o
);
    localparam logic [SRC_W-1:0] PARENTS = parent_bits();

    logic [NUM_GRP-1:0]   grp_on;
    logic [SUB_W-1:0]     live;

    assign live = sub_pend_i & ~sub_mask_i;

    for (genvar g = 0; g < NUM_GRP; g++) begin : g_grp
        localparam logic [SUB_W-1:0] BITS = grp_bits(g);
        assign grp_on[g] = |(live & BITS);
    end

    always_comb begin
        line_o = req_i & ~PARENTS & ~RSVD_LINES;
        for (int g = 0; g < int'(NUM_GRP); g++)
            line_o[GRP_PARENT[g]] = grp_on[g];
    end
endmodule

// File: rtl/intc_serve_fsm.sv
module intc_serve_fsm
    import intc_pkg::*;
#(
    parameter int unsigned N = SRC_LINES,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic [N-1:0]  cand_i,
    input  logic [N-1:0]  clr_i,
    output logic [N-1:0]  serve_o,
    output logic [IW-1:0] idx_o,
    output logic          busy_o
);
    serve_state_e state, state_nx;
    logic [IW-1:0] pick;
    logic          retire;

    assign pick   = first_set(cand_i);
    assign retire = (clr_i & serve_o) != '0;

    always_comb begin
        state_nx = state;
        unique case (state)
            ST_IDLE:  if (cand_i != '0) state_nx = ST_SERVE;
            ST_SERVE: if (retire)       state_nx = ST_IDLE;
            default:                    state_nx = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) state <= ST_IDLE;
        else        state <= state_nx;
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            serve_o <= '0;
            idx_o   <= '0;
        end else if (state == ST_IDLE && state_nx == ST_SERVE) begin
            serve_o <= {{(N-1){1'b0}}, 1'b1} << pick;
            idx_o   <= pick;
        end else if (state == ST_SERVE && state_nx == ST_IDLE) begin
            serve_o <= '0;
            idx_o   <= '0;
        end
    end

    assign busy_o = (state == ST_SERVE);

    // R5
    one_served_chk: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(serve_o));

    // R5
    no_preempt_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (busy_o && !retire) |=> $stable(serve_o));

    // R5
    arm_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!busy_o && cand_i != '0) |=> busy_o);
endmodule

// File: rtl/cascade_intc.sv
module cascade_intc
    import intc_pkg::*;
#(
    parameter int unsigned NUM_SRC = SRC_LINES,
    parameter int unsigned NUM_SUB = SUB_LINES,
    localparam int unsigned IDX_W  = $clog2(NUM_SRC)
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic [NUM_SRC-1:0] irq_req,
    input  logic [NUM_SUB-1:0] sub_req,
    input  logic [2:0]         bus_addr,
    input  logic               bus_we,
    input  logic [31:0]        bus_wdata,
    output logic [31:0]        bus_rdata,
    output logic               irq_o,
    output logic               fiq_o,
    output logic [IDX_W-1:0]   serve_idx
);
    logic [NUM_SRC-1:0] mask_q, mode_q, src_pend, serve_bits, line_eff;
    logic [NUM_SRC-1:0] src_clr, serve_clr, cand;
    logic [NUM_SUB-1:0] sub_mask_q, sub_pend, sub_clr;

    always_comb begin
        src_clr   = '0;
        serve_clr = '0;
        sub_clr   = '0;
        if (bus_we) begin
            if (bus_addr == RA_SRCPEND) src_clr   = bus_wdata[NUM_SRC-1:0];
            if (bus_addr == RA_SERVE)   serve_clr = bus_wdata[NUM_SRC-1:0];
            if (bus_addr == RA_SUBPEND) sub_clr   = bus_wdata[NUM_SUB-1:0];
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            mask_q     <= '1;
            mode_q     <= '0;
            sub_mask_q <= '1;
        end else if (bus_we) begin
            if (bus_addr == RA_MASK)    mask_q     <= bus_wdata[NUM_SRC-1:0];
            if (bus_addr == RA_MODE)    mode_q     <= bus_wdata[NUM_SRC-1:0];
            if (bus_addr == RA_SUBMASK) sub_mask_q <= bus_wdata[NUM_SUB-1:0];
        end
    end

    intc_pend_latch #(.W(NUM_SUB)) u_sub_pend (
        .clk(clk), .rst_n(rst_n), .line_i(sub_req), .clr_i(sub_clr), .pend_o(sub_pend)
    );

    intc_sub_fold #(.SRC_W(NUM_SRC), .SUB_W(NUM_SUB)) u_fold (
        .sub_pend_i(sub_pend), .sub_mask_i(sub_mask_q), .req_i(irq_req), .line_o(line_eff)
    );

    intc_pend_latch #(.W(NUM_SRC)) u_src_pend (
        .clk(clk), .rst_n(rst_n), .line_i(line_eff), .clr_i(src_clr), .pend_o(src_pend)
    );

    assign cand  = src_pend & ~mask_q & ~mode_q;
    assign fiq_o = |(src_pend & ~mask_q & mode_q);

    intc_serve_fsm #(.N(NUM_SRC)) u_serve (
        .clk(clk), .rst_n(rst_n), .cand_i(cand), .clr_i(serve_clr),
        .serve_o(serve_bits), .idx_o(serve_idx), .busy_o(irq_o)
    );

    always_comb begin
        bus_rdata = '0;
        case (bus_addr)
            RA_SRCPEND: bus_rdata[NUM_SRC-1:0] = src_pend;
            RA_MASK:    bus_rdata[NUM_SRC-1:0] = mask_q;
            RA_MODE:    bus_rdata[NUM_SRC-1:0] = mode_q;
            RA_SERVE:   bus_rdata[NUM_SRC-1:0] = serve_bits;
            RA_OFFSET:  bus_rdata[IDX_W-1:0]   = serve_idx;
            RA_SUBPEND: bus_rdata[NUM_SUB-1:0] = sub_pend;
            RA_SUBMASK: bus_rdata[NUM_SUB-1:0] = sub_mask_q;
            default:    bus_rdata = '0;
        endcase
    end

    // R9
    rsvd_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (src_pend & RSVD_LINES) == '0);

    // R10
    no_fast_route_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (mode_q == '0) |-> !fiq_o);

    // R8
    sub_kept_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (sub_clr == '0) |=> ((sub_pend & $past(sub_pend)) == $past(sub_pend)));
endmodule

// File: tb/cascade_intc_bench.sv
module cascade_intc_bench;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic [31:0] irq_req = '0;
    logic [10:0] sub_req = '0;
    logic [2:0]  bus_addr = '0;
    logic        bus_we = 1'b0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        irq_o, fiq_o;
    logic [4:0]  serve_idx;

    int checks = 0;
    int fails  = 0;
    bit done   = 1'b0;

    always #(CLK_PERIOD/2) clk = ~clk;

    cascade_intc u_cascade_intc (
        .clk(clk), .rst_n(rst_n), .irq_req(irq_req), .sub_req(sub_req),
        .bus_addr(bus_addr), .bus_we(bus_we), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .irq_o(irq_o), .fiq_o(fiq_o), .serve_idx(serve_idx)
    );

    task automatic check(input string tag, input logic [31:0] act, input logic [31:0] exp);
        checks++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic cycles(input int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_addr = a; bus_wdata = d; bus_we = 1'b1;
        @(negedge clk);
        bus_we = 1'b0;
    endtask

    task automatic rd(input logic [2:0] a, output logic [31:0] d);
        @(negedge clk);
        bus_addr = a;
        #1 d = bus_rdata;
    endtask

    task automatic rdchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
        logic [31:0] d;
        rd(a, d);
        check(tag, d, exp);
    endtask

    task automatic t_reset;
        rdchk("R1 srcpend", 3'd0, 32'h0);
        rdchk("R1 mask", 3'd1, 32'hFFFF_FFFF);
        rdchk("R1 mode", 3'd2, 32'h0);
        rdchk("R1 serve", 3'd3, 32'h0);
        rdchk("R1 offset", 3'd4, 32'h0);
        rdchk("R1 subpend", 3'd5, 32'h0);
        rdchk("R11 submask at 6", 3'd6, 32'h7FF);
        rdchk("R11 addr 7", 3'd7, 32'h0);
        check("R1 irq", {31'b0, irq_o}, 32'h0);
        check("R1 fiq", {31'b0, fiq_o}, 32'h0);
    endtask

    task automatic t_edge;
        wr(3'd1, 32'h0);
        @(negedge clk) irq_req[5] = 1'b1;
        cycles(3);
        rdchk("R2 latch", 3'd0, 32'h20);
        check("R6 serve_idx", {27'b0, serve_idx}, 32'd5);
        rdchk("R6 offset", 3'd4, 32'd5);
        check("R5 irq", {31'b0, irq_o}, 32'h1);
        wr(3'd0, 32'h0);
        rdchk("R3 zero write", 3'd0, 32'h20);
        wr(3'd0, 32'h20);
        wr(3'd3, 32'h20);
        cycles(2);
        rdchk("R2 level no reset", 3'd0, 32'h0);
        check("R3 retire irq", {31'b0, irq_o}, 32'h0);
        irq_req[5] = 1'b0;
    endtask

    task automatic t_mask;
        wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk) irq_req[9] = 1'b1;
        cycles(3);
        rdchk("R4 recorded", 3'd0, 32'h200);
        check("R4 blocked", {31'b0, irq_o}, 32'h0);
        wr(3'd1, ~32'h200);
        cycles(2);
        check("R4 unmasked irq", {31'b0, irq_o}, 32'h1);
        check("R4 idx", {27'b0, serve_idx}, 32'd9);
        wr(3'd0, 32'h200);
        wr(3'd3, 32'h200);
        irq_req[9] = 1'b0;
        wr(3'd1, 32'h0);
    endtask

    task automatic t_priority;
        @(negedge clk) irq_req[12] = 1'b1;
        cycles(3);
        check("R5 first", {27'b0, serve_idx}, 32'd12);
        @(negedge clk) irq_req[3] = 1'b1;
        cycles(3);
        rdchk("R5 no preempt", 3'd3, 32'h1000);
        wr(3'd0, 32'h1000);
        wr(3'd3, 32'h1000);
        cycles(2);
        rdchk("R5 next lowest", 3'd3, 32'h8);
        check("R6 idx 3", {27'b0, serve_idx}, 32'd3);
        wr(3'd0, 32'h8);
        wr(3'd3, 32'h8);
        irq_req[12] = 1'b0; irq_req[3] = 1'b0;
        @(negedge clk) begin irq_req[6] = 1'b1; irq_req[24] = 1'b1; end
        cycles(3);
        rdchk("R9 reserved", 3'd0, 32'h0);
        check("R9 no irq", {31'b0, irq_o}, 32'h0);
        irq_req[6] = 1'b0; irq_req[24] = 1'b0;
    endtask

    task automatic t_sub;
        wr(3'd6, 32'h0);
        @(negedge clk) irq_req[28] = 1'b1;
        cycles(3);
        rdchk("R7 parent input ignored", 3'd0, 32'h0);
        irq_req[28] = 1'b0;
        @(negedge clk) sub_req[4] = 1'b1;
        cycles(4);
        rdchk("R7 sub latched", 3'd5, 32'h10);
        rdchk("R7 parent 23", 3'd0, 32'h0080_0000);
        check("R7 idx 23", {27'b0, serve_idx}, 32'd23);
        wr(3'd0, 32'h0080_0000);
        wr(3'd3, 32'h0080_0000);
        cycles(2);
        rdchk("R8 sub kept", 3'd5, 32'h10);
        wr(3'd5, 32'h10);
        rdchk("R8 sub cleared", 3'd5, 32'h0);
        sub_req[4] = 1'b0;
        wr(3'd6, 32'h200);
        @(negedge clk) sub_req[9] = 1'b1;
        cycles(3);
        rdchk("R7 masked sub pend", 3'd5, 32'h200);
        rdchk("R7 masked no parent", 3'd0, 32'h0);
        wr(3'd6, 32'h0);
        cycles(3);
        rdchk("R7 parent 31", 3'd0, 32'h8000_0000);
        check("R7 idx 31", {27'b0, serve_idx}, 32'd31);
        wr(3'd5, 32'h200);
        wr(3'd0, 32'h8000_0000);
        wr(3'd3, 32'h8000_0000);
        sub_req[9] = 1'b0;
    endtask

    task automatic t_fast;
        wr(3'd2, 32'h0002_0000);
        @(negedge clk) irq_req[17] = 1'b1;
        cycles(3);
        check("R10 fiq", {31'b0, fiq_o}, 32'h1);
        check("R10 no irq", {31'b0, irq_o}, 32'h0);
        wr(3'd0, 32'h0002_0000);
        check("R10 fiq drop", {31'b0, fiq_o}, 32'h0);
        wr(3'd2, 32'h0);
        irq_req[17] = 1'b0;
        @(negedge clk) irq_req[20] = 1'b1;
        cycles(3);
        check("R10 mode zero", {31'b0, fiq_o}, 32'h0);
        check("R10 normal path", {27'b0, serve_idx}, 32'd20);
        wr(3'd0, 32'h0010_0000);
        wr(3'd3, 32'h0010_0000);
        irq_req[20] = 1'b0;
    endtask

    task automatic t_setwins;
        wr(3'd1, 32'hFFFF_FFFF);
        @(negedge clk);
        irq_req[2] = 1'b1;
        bus_addr = 3'd0; bus_wdata = 32'h4; bus_we = 1'b1;
        @(negedge clk) bus_we = 1'b0;
        rdchk("R3 set wins", 3'd0, 32'h4);
        wr(3'd0, 32'h4);
        rdchk("R3 then cleared", 3'd0, 32'h0);
        irq_req[2] = 1'b0;
    endtask

    task automatic finish_up;
        if (!done) begin
            done = 1'b1;
            $display("== %0d vectors applied, %0d miscompares ==", checks, fails);
            $finish;
        end
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_up();
    end

    initial begin
        cycles(3);
        rst_n = 1'b1;
        t_reset();
        t_edge();
        t_mask();
        t_priority();
        t_sub();
        t_fast();
        t_setwins();
        finish_up();
    end
endmodule